// File: doc/BRIEF.md
# Valid-Propagating Four-Operation Arithmetic Unit

This block is a registered arithmetic unit with two operand inputs and one operation input. Each input carries its own valid flag beside its data. On every clock edge the unit computes bitwise AND, addition, subtraction or multiplication of the operands, as picked by the operation code, and registers the result. The result carries its own valid flag. That flag is set only when every input the result depends on was valid in the same cycle. A missing operand or operation token therefore shows up as an invalid result, never as a stale value.

An invalid result always carries all-zero data, so downstream logic never has to mask it. A build-time option holds the multiplier operands at zero whenever no valid multiply is requested. This cuts multiplier toggling without changing any visible result.

The unit accepts a new set of inputs on every cycle and has no back-pressure: there is no ready signal. The consumer must take each result in the cycle it appears, or register it.

Top module: `vpalu_top`

## Requirements
- R1: With operation code 2'b00 and all inputs valid, the result is the bitwise AND of the two operands.
- R2: With operation code 2'b01 and all inputs valid, the result is the operand sum modulo 2^DW.
- R3: With operation code 2'b10 and all inputs valid, the result is operand A minus operand B modulo 2^DW, wrapping on borrow.
- R4: With operation code 2'b11 and all inputs valid, the result is the low DW bits of the product of A and B.
- R5: The result valid flag equals the AND of the A, B and operation valid flags sampled at the previous clock edge.
- R6: Whenever the result valid flag is 0, the result data is all zeros.
- R7: Every result appears exactly one clock edge after its inputs are sampled. A new input set is accepted on every cycle, with no stall.
- R8: While reset is asserted, the result valid flag and the result data are 0.
- R9: With ISOLATE=1, both multiplier operands are zero unless the operation is valid and equal to 2'b11. The visible results stay as in R1 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_data | input | DW | Operand A data |
| a_vld | input | 1 | Operand A valid flag |
| b_data | input | DW | Operand B data |
| b_vld | input | 1 | Operand B valid flag |
| op_code | input | 2 | Operation select: 00 AND, 01 ADD, 10 SUB, 11 MULT |
| op_vld | input | 1 | Operation valid flag |
| res_data | output | DW | Result data, zero when invalid |
| res_vld | output | 1 | Result valid flag |

## Verification
Each result and its valid flag are due exactly one rising edge after the inputs that produced them. The bench changes inputs on the falling edge, waits for the next rising edge and samples a nanosecond later. Every comparison therefore pairs one input set with the result registered from it. Inputs change on every cycle back to back, so a result that arrives late or is held longer than one cycle is compared against the wrong expected value and reported.

// File: rtl/vpalu_pkg.sv
package vpalu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10,
    OP_MUL = 2'b11
  } vpalu_op_e;

  localparam int unsigned OP_W = 2;
endpackage

// File: rtl/vpalu_iso.sv
module vpalu_iso
  import vpalu_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter bit          ISOLATE = 1'b1
) (
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   b_in,
  input  logic [OP_W-1:0] op_in,
  input  logic            op_ok,
  output logic [DW-1:0]   mul_a,
  output logic [DW-1:0]   mul_b
);
  generate
    if (ISOLATE) begin : g_gate
      logic use_mul;
      assign use_mul = op_ok && (vpalu_op_e'(op_in) == OP_MUL);
      assign mul_a   = use_mul ? a_in : '0;
      assign mul_b   = use_mul ? b_in : '0;
    end else begin : g_pass
      assign mul_a = a_in;
      assign mul_b = b_in;
    end
  endgenerate
endmodule

// File: rtl/vpalu_core.sv
module vpalu_core
  import vpalu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   b_in,
  input  logic [DW-1:0]   mul_a,
  input  logic [DW-1:0]   mul_b,
  input  logic [OP_W-1:0] op_in,
  output logic [DW-1:0]   raw
);
  logic [DW-1:0] and_r, add_r, sub_r, mul_r;

  assign and_r = a_in & b_in;
  assign add_r = a_in + b_in;
  assign sub_r = a_in - b_in;
  assign mul_r = mul_a * mul_b;

  always_comb begin
    unique case (vpalu_op_e'(op_in))
      OP_AND:  raw = and_r;
      OP_ADD:  raw = add_r;
      OP_SUB:  raw = sub_r;
      default: raw = mul_r;
    endcase
  end
endmodule

// File: rtl/vpalu_vgate.sv
module vpalu_vgate #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NSUP = 3
) (
  input  logic [NSUP-1:0] sup_vld,
  input  logic [DW-1:0]   raw,
  output logic            out_vld,
  output logic [DW-1:0]   out_data
);
  assign out_vld  = &sup_vld;
  assign out_data = out_vld ? raw : '0;
endmodule

// File: rtl/vpalu_top.sv
module vpalu_top
  import vpalu_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter bit          ISOLATE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   a_data,
  input  logic            a_vld,
  input  logic [DW-1:0]   b_data,
  input  logic            b_vld,
  input  logic [1:0]      op_code,
  input  logic            op_vld,
  output logic [DW-1:0]   res_data,
  output logic            res_vld
);
  localparam int unsigned NSUP = 3;

  logic [DW-1:0] mul_a, mul_b, raw, gated;
  logic          nxt_vld;

  vpalu_iso #(.DW(DW), .ISOLATE(ISOLATE)) u_iso (
    .a_in(a_data), .b_in(b_data), .op_in(op_code), .op_ok(op_vld),
    .mul_a(mul_a), .mul_b(mul_b)
  );

  vpalu_core #(.DW(DW)) u_core (
    .a_in(a_data), .b_in(b_data), .mul_a(mul_a), .mul_b(mul_b),
    .op_in(op_code), .raw(raw)
  );

  vpalu_vgate #(.DW(DW), .NSUP(NSUP)) u_vg (
    .sup_vld({a_vld, b_vld, op_vld}), .raw(raw),
    .out_vld(nxt_vld), .out_data(gated)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_data <= '0;
    end else begin
      res_vld  <= nxt_vld;
      res_data <= gated;
    end
  end
endmodule

// File: rtl/vpalu_chk.sv
module vpalu_chk #(
  parameter int unsigned DW      = 32,
  parameter bit          ISOLATE = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] a_data,
  input logic          a_vld,
  input logic [DW-1:0] b_data,
  input logic          b_vld,
  input logic [1:0]    op_code,
  input logic          op_vld,
  input logic [DW-1:0] res_data,
  input logic          res_vld,
  input logic [DW-1:0] mul_a,
  input logic [DW-1:0] mul_b
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!res_vld && res_data == '0)); // R8
  AST_VALID_SUPPORT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (res_vld == $past(a_vld && b_vld && op_vld))); // R5
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> (res_data == '0)); // R6
  AST_AND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(op_code) == 2'b00) |-> (res_data == ($past(a_data) & $past(b_data)))); // R1
  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(op_code) == 2'b01) |-> (res_data == DW'($past(a_data) + $past(b_data)))); // R2
  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(op_code) == 2'b10) |-> (res_data == DW'($past(a_data) - $past(b_data)))); // R3
  generate
    if (ISOLATE) begin : g_iso_chk
      AST_MUL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_vld && op_code == 2'b11) |-> (mul_a == '0 && mul_b == '0)); // R9
    end
  endgenerate
endmodule

bind vpalu_top vpalu_chk #(.DW(DW), .ISOLATE(ISOLATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_data(a_data), .a_vld(a_vld),
  .b_data(b_data), .b_vld(b_vld), .op_code(op_code), .op_vld(op_vld),
  .res_data(res_data), .res_vld(res_vld), .mul_a(mul_a), .mul_b(mul_b)
);

// File: tb/sim_vpalu_top.sv
`timescale 1ns/1ps
module sim_vpalu_top;
  localparam int unsigned DW = 8;
  localparam int unsigned MASK = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic          a_vld = 1'b0, b_vld = 1'b0, op_vld = 1'b0;
  logic [1:0]    op_code = 2'b00;
  logic [DW-1:0] res_data;
  logic          res_vld;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vpalu_top #(.DW(DW), .ISOLATE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .a_data(a_data), .a_vld(a_vld),
    .b_data(b_data), .b_vld(b_vld), .op_code(op_code), .op_vld(op_vld),
    .res_data(res_data), .res_vld(res_vld)
  );

  function automatic int unsigned ref_val(int unsigned a, int unsigned b, int unsigned op);
    case (op)
      0: return a & b;
      1: return (a + b) & MASK;
      2: return (a + (1 << DW) - b) & MASK;
      default: return (a * b) & MASK;
    endcase
  endfunction

  task automatic check(string req, bit exp_v, int unsigned exp_d);
    checks++;
    if (res_vld !== exp_v || int'(res_data) != int'(exp_d) || $isunknown(res_data)) begin
      failures++;
      $display("FAIL %s: got vld=%0b data=%0h, expected vld=%0b data=%0h",
               req, res_vld, res_data, exp_v, exp_d[DW-1:0]);
    end
  endtask

  // drive on falling edge, sample 1 ns after the next rising edge
  task automatic step(string req, int unsigned a, int unsigned b, int unsigned op,
                      bit av, bit bv, bit ov);
    bit ev;
    @(negedge clk);
    a_data = DW'(a); b_data = DW'(b); op_code = 2'(op);
    a_vld = av; b_vld = bv; op_vld = ov;
    ev = av && bv && ov;
    @(posedge clk);
    #1;
    check(req, ev, ev ? ref_val(a, b, op) : 0);
  endtask

  initial begin
    string tag;
    // R8: reset state
    #2;
    check("R8", 1'b0, 0);
    @(negedge clk);
    a_vld = 1'b1; b_vld = 1'b1; op_vld = 1'b1; a_data = 8'h5A; b_data = 8'h33;
    @(posedge clk); #1;
    check("R8", 1'b0, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1..R4 sweep with back-to-back issue (R7)
    for (int op = 0; op < 4; op++) begin
      tag = (op == 0) ? "R1" : (op == 1) ? "R2" : (op == 2) ? "R3" : "R4";
      for (int a = 0; a < 256; a++)
        for (int bj = 0; bj < 16; bj++)
          step(tag, a, (bj * 17 + a / 16) & MASK, op, 1'b1, 1'b1, 1'b1);
    end

    // R3 wrap and R4 truncation corners
    step("R3", 0, 1, 2, 1'b1, 1'b1, 1'b1);
    step("R4", 255, 255, 3, 1'b1, 1'b1, 1'b1);
    step("R2", 255, 1, 1, 1'b1, 1'b1, 1'b1);

    // R5/R6: every valid pattern for every operation
    for (int op = 0; op < 4; op++)
      for (int vp = 0; vp < 8; vp++)
        for (int k = 0; k < 8; k++)
          step(vp == 7 ? "R5" : "R6", (k * 37 + 11) & MASK, (k * 53 + 200) & MASK, op,
               vp[2], vp[1], vp[0]);

    // R7: valid result lasts one cycle only, then invalid input clears it
    step("R7", 9, 7, 3, 1'b1, 1'b1, 1'b1);
    step("R7", 9, 7, 3, 1'b1, 1'b1, 1'b0);

    // R9: non-multiply ops after a multiply stay correct with isolation on
    step("R9", 200, 100, 3, 1'b1, 1'b1, 1'b1);
    step("R9", 200, 100, 1, 1'b1, 1'b1, 1'b1);
    step("R9", 200, 100, 2, 1'b1, 1'b1, 1'b1);
    step("R9", 200, 100, 3, 1'b1, 1'b1, 1'b1);

    // R8: reset asserted mid-stream clears output
    @(negedge clk);
    a_vld = 1'b1; b_vld = 1'b1; op_vld = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R8", 1'b0, 0);
    @(posedge clk); #1;
    check("R8", 1'b0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule